// File: doc/BRIEF.md
# Serial Divide-by-Five Sequencer

This block divides an unsigned dividend by the constant five. It uses no adder or subtractor. A load pulse captures the dividend. The block then takes one dividend bit per clock, most significant bit first. Each bit moves a five-state remainder machine, and each step shifts one quotient bit into a shift register. A down-counter holds the number of bits still to process, and a run flag gates the stepping.

When the count runs out, a one-cycle completion pulse is raised. The quotient, a 3-bit remainder and a remainder-is-zero flag are then valid, and they stay unchanged until the next accepted load. A caller pulses load while the block is idle, waits for the completion pulse, and then reads the results.

Top module: `div5_serial`

## Requirements
- R1: After reset the block is idle. Busy and done are low, the quotient is 0, the remainder is 0 and the zero flag is high.
- R2: A load sampled high while idle captures the dividend. Busy is high from the next cycle. Done rises exactly DW clock edges after the load edge, and busy falls on that same edge.
- R3: Bits are taken most significant first from a remainder state that starts at 0. The state moves as follows for input bit 0 / bit 1: 0→0/1, 1→2/3, 2→4/0, 3→1/2, 4→3/4. The step's quotient bit is 1 for state 2 with bit 1, and for states 3 and 4 with either bit. It is 0 otherwise. The final quotient equals floor(dividend/5) on DW-2 bits.
- R4: The remainder output is the final state as a 3-bit binary number from 000 to 100, equal to dividend mod 5.
- R5: The zero flag is high exactly when the final remainder is 0.
- R6: Done is high for one cycle only, and busy is low while done is high.
- R7: While idle and with no load, the quotient and remainder do not change, whatever the dividend input does.
- R8: A load that arrives while busy has no effect. The run in progress ends at its original time with the results of the first dividend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start pulse, accepted only while idle |
| dividend_i | input | DW | Unsigned dividend captured on an accepted load |
| busy_o | output | 1 | High while bits are being processed |
| done_o | output | 1 | One-cycle pulse when the results become valid |
| quotient_o | output | DW-2 | Quotient floor(dividend/5) |
| remainder_o | output | 3 | Remainder dividend mod 5 |
| rem_zero_o | output | 1 | High when the remainder is zero |

## Verification
The assertions take two things for granted. First, reset is released synchronously to the clock. Second, load_i and dividend_i hold a defined value at each rising edge, so that the idle-hold property can relate them to the outputs. The bench changes every input only on the falling edge, and it drives load as a clean pulse one cycle long. It also changes dividend_i while idle without pulsing load. It raises load during a run only in the scenario that checks that such a load is ignored.

// File: rtl/div5_pkg.sv
package div5_pkg;

    typedef enum logic [2:0] {
        RS0 = 3'd0,
        RS1 = 3'd1,
        RS2 = 3'd2,
        RS3 = 3'd3,
        RS4 = 3'd4
    } rstate_t;

    // Next remainder after appending one dividend bit.
    function automatic rstate_t rs_next(input rstate_t s, input logic b);
        rstate_t n;
        case (s)
            RS0:     n = b ? RS1 : RS0;
            RS1:     n = b ? RS3 : RS2;
            RS2:     n = b ? RS0 : RS4;
            RS3:     n = b ? RS2 : RS1;
            RS4:     n = b ? RS4 : RS3;
            default: n = RS0;
        endcase
        return n;
    endfunction

    // Quotient bit emitted when the partial value reaches five or more.
    function automatic logic rs_qbit(input rstate_t s, input logic b);
        logic q;
        case (s)
            RS2:     q = b;
            RS3:     q = 1'b1;
            RS4:     q = 1'b1;
            default: q = 1'b0;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/div5_step.sv
module div5_step
    import div5_pkg::*;
(
    input  rstate_t state_i,
    input  logic    bit_i,
    output rstate_t state_o,
    output logic    qbit_o
);

    always_comb begin
        state_o = rs_next(state_i, bit_i);
        qbit_o  = rs_qbit(state_i, bit_i);
    end

endmodule

// File: rtl/div5_ctrl.sv
module div5_ctrl #(
    parameter int DW = 13,
    localparam int CW = $clog2(DW + 1)
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic load_i,
    output logic start_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        start_o  = load_i && !c_q.busy;
        step_o   = c_q.busy;
        if (start_o) begin
            c_d.cnt  = CW'(DW);
            c_d.busy = 1'b1;
        end else if (c_q.busy) begin
            c_d.cnt = c_q.cnt - CW'(1);
            if (c_q.cnt == CW'(1)) begin
                c_d.busy = 1'b0;
                c_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) c_q <= '0;
        else          c_q <= c_d;
    end

    assign busy_o = c_q.busy;
    assign done_o = c_q.done;

    // R2: an accepted load arms the full count
    a_r2_start_arms: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (load_i && !c_q.busy) |=> (c_q.busy && c_q.cnt == CW'(DW)));

    // R8: while running the count drops by one per clock regardless of load
    a_r8_count_down: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (c_q.busy && c_q.cnt > CW'(1)) |=> (c_q.busy && c_q.cnt == $past(c_q.cnt) - CW'(1)));

    // R6: done lasts one cycle and never overlaps busy
    a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        c_q.done |=> !c_q.done);
    a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        c_q.done |-> !c_q.busy);

endmodule

// File: rtl/div5_serial.sv
module div5_serial
    import div5_pkg::*;
#(
    parameter int DW = 13,
    localparam int QW = DW - 2
) (
    input  logic          clk_i,
    input  logic          rst_n_i,
    input  logic          load_i,
    input  logic [DW-1:0] dividend_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [QW-1:0] quotient_o,
    output logic [2:0]    remainder_o,
    output logic          rem_zero_o
);

    typedef struct packed {
        logic [DW-1:0] dvd;
        rstate_t       state;
        logic [QW-1:0] quo;
    } dp_t;

    dp_t     dp_d, dp_q;
    logic    start_w, step_w, qbit_w;
    rstate_t nstate_w;

    div5_ctrl #(.DW(DW)) ctrl_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .load_i  (load_i),
        .start_o (start_w),
        .step_o  (step_w),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    div5_step step_i (
        .state_i (dp_q.state),
        .bit_i   (dp_q.dvd[DW-1]),
        .state_o (nstate_w),
        .qbit_o  (qbit_w)
    );

    always_comb begin
        dp_d = dp_q;
        if (start_w) begin
            dp_d.dvd   = dividend_i;
            dp_d.state = RS0;
            dp_d.quo   = '0;
        end else if (step_w) begin
            dp_d.dvd   = dp_q.dvd << 1;
            dp_d.state = nstate_w;
            dp_d.quo   = QW'({dp_q.quo, qbit_w});
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            dp_q.dvd   <= '0;
            dp_q.state <= RS0;
            dp_q.quo   <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign quotient_o  = dp_q.quo;
    assign remainder_o = dp_q.state;
    assign rem_zero_o  = (dp_q.state == RS0);

    // R4: remainder never leaves 0..4
    a_r4_rem_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        remainder_o <= 3'd4);

    // R7: idle without load keeps results frozen
    a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!busy_o && !load_i) |=> ($stable(quotient_o) && $stable(remainder_o)));

endmodule

// File: tb/div5_serial_tb_top.sv
module div5_serial_tb_top;

    localparam int DW = 8;
    localparam int QW = DW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [DW-1:0] dvd = '0;
    logic          busy, done, rzero;
    logic [QW-1:0] quo;
    logic [2:0]    rem;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    div5_serial #(.DW(DW)) dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .load_i      (load),
        .dividend_i  (dvd),
        .busy_o      (busy),
        .done_o      (done),
        .quotient_o  (quo),
        .remainder_o (rem),
        .rem_zero_o  (rzero)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 quotient", quo, 0);
        check("R1 remainder", rem, 0);
        check("R1 zero flag", rzero, 1);
    endtask

    // Runs one division; optional intruding load at step 'poke' (0 = none).
    task automatic t_divide(input int val, input int poke, input int other);
        int q = val / 5;
        int r = val % 5;
        @(negedge clk);
        dvd  = DW'(val);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check("R2 busy after load", busy, 1);
        for (int k = 1; k <= DW; k++) begin
            if (k == poke) begin
                load = 1'b1;
                dvd  = DW'(other);
            end
            @(negedge clk);
            load = 1'b0;
            if (k < DW) begin
                if (done !== 1'b0 || busy !== 1'b1)
                    check("R2 run in progress", {30'd0, busy, done}, 2);
            end
        end
        check("R2 done at DW edges", done, 1);
        check("R6 busy low with done", busy, 0);
        check(poke ? "R8 quotient" : "R3 quotient", quo, q);
        check(poke ? "R8 remainder" : "R4 remainder", rem, r);
        check("R5 zero flag", rzero, (r == 0) ? 1 : 0);
        @(negedge clk);
        check("R6 done one cycle", done, 0);
    endtask

    task automatic t_hold();
        int q0 = quo;
        int r0 = rem;
        for (int k = 0; k < 6; k++) begin
            dvd = DW'(k * 37 + 11);
            @(negedge clk);
            check("R7 quotient held", quo, q0);
            check("R7 remainder held", rem, r0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divide(2 ** DW - 1, 0, 0);
        t_divide(0, 0, 0);
        t_hold();
        t_divide(123, 3, 255);
        t_divide(254, DW - 1, 1);
        t_hold();
        for (int v = 0; v < 2 ** DW; v++) t_divide(v, 0, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule